// File: doc/BRIEF.md
# Enhanced parallel port mode controller

This block owns the operating mode of an enhanced-capability parallel port. The host writes a 3-bit mode field, a direction bit and two software control bits (strobe and autoFd) through one register write port. The block reports the mode and direction it is actually using, and it refuses any mode or direction change that the transition rules forbid. Modes 000 and 001 leave the port lines under software control. Modes 010 and 011 hand the lines to a hardware handshake engine, which moves bytes between the port and external FIFOs. FIFO storage lives outside the block; only its available, full, pop and push signals cross the boundary.

The engine is a five-state machine. HS_IDLE goes to HS_FWD_STROBE when a forward byte is popped, or to HS_REV_WAIT in reverse. HS_FWD_STROBE goes to HS_FWD_HOLD when Busy is high, and HS_FWD_HOLD goes back to HS_IDLE when Busy is low. HS_REV_WAIT goes to HS_REV_ACK when nAck is low and the reverse FIFO is not full. HS_REV_ACK goes back to HS_REV_WAIT when nAck is high, and pushes the byte on that step. Leaving a hardware mode forces every state back to HS_IDLE.

When software leaves a forward hardware mode, the block first releases the port lines for one cycle and only then applies the new mode. When software leaves reverse, the block applies the new mode at once, drops nAutoFd at the same time, and never pushes the half-finished byte.

Top module: `ecp_mode_ctrl`

## Requirements
- R1: After reset the block shows mode 000, direction 0, nStrobe and nAutoFd high, data drivers enabled, and the engine idle.
- R2: In any non-hardware mode, nStrobe shows the inverse of the strobe bit and nAutoFd shows the inverse of the autoFd bit, one cycle after the write.
- R3: From mode 000 or 001, a write of any mode is accepted. From any other mode, only 000 or 001 is accepted and every other mode value is ignored.
- R4: The direction bit takes the written value only when the mode before the write is 001; otherwise it keeps its value. The data drivers are enabled (pp_data_oe=1) exactly when direction is 0 (forward).
- R5: In mode 010 or 011 with direction 0, the block pops the address FIFO first and the data FIFO second. It puts the byte on the bus and drives nStrobe low until Busy rises, then releases nStrobe and waits for Busy to fall. During the transfer nAutoFd is low for an address byte and high for a data byte. Neither FIFO is popped in any other mode or direction.
- R6: An accepted write that leaves forward hardware mode makes nStrobe and nAutoFd high on the next cycle. The new mode shows one cycle later. Any write made during that settling cycle is ignored, including its strobe and autoFd bits.
- R7: In reverse hardware mode, while nAck is low and the reverse FIFO is not full, the block latches the bus byte and drives nAutoFd low. While the FIFO is full, it does not answer.
- R8: When nAck returns high after the acknowledge, the block pushes the latched byte into the reverse FIFO for one cycle and releases nAutoFd.
- R9: An accepted write that leaves reverse hardware mode changes the mode at once and sets nAutoFd high on the same cycle. The byte in flight is never pushed.
- R10: The idle output is high only when the engine is in HS_IDLE. The drained output is high only when the engine is idle and both forward FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_mode | input | 3 | Requested mode |
| reg_dir | input | 1 | Requested direction (1 = reverse) |
| reg_strobe | input | 1 | Software strobe bit (1 drives nStrobe low) |
| reg_autofd | input | 1 | Software autoFd bit (1 drives nAutoFd low) |
| mode_o | output | 3 | Mode in effect |
| dir_o | output | 1 | Direction in effect |
| afifo_avail | input | 1 | Address/RLE FIFO holds a byte |
| afifo_byte | input | DATA_W | Head byte of the address/RLE FIFO |
| afifo_pop | output | 1 | Takes the head address/RLE byte |
| dfifo_avail | input | 1 | Forward data FIFO holds a byte |
| dfifo_byte | input | DATA_W | Head byte of the forward data FIFO |
| dfifo_pop | output | 1 | Takes the head data byte |
| rfifo_full | input | 1 | Reverse FIFO is full |
| rfifo_push | output | 1 | Writes a received byte into the reverse FIFO |
| rfifo_byte | output | DATA_W | Received byte |
| xfer_idle_o | output | 1 | Handshake engine idle |
| fwd_drained_o | output | 1 | Engine idle and both forward FIFOs empty |
| pp_nstrobe_o | output | 1 | Port nStrobe |
| pp_nautofd_o | output | 1 | Port nAutoFd |
| pp_busy_i | input | 1 | Port Busy |
| pp_nack_i | input | 1 | Port nAck |
| pp_data_o | output | DATA_W | Port data out |
| pp_data_i | input | DATA_W | Port data in |
| pp_data_oe | output | 1 | Port data driver enable |

## Verification
Mode and direction take effect on the clock edge that samples the write. The one exception is leaving forward hardware mode, where the mode appears one edge later. The port pins come from a register that follows the engine state, so a state change reaches the pins one edge after it happens. The pop and push pulses, by contrast, are combinational from the current state. The bench drives inputs on falling edges and counts edges to each result under this rule: it samples pops and pushes in the same half cycle as the input that causes them, and samples the pins one falling edge after the state change.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_FWD_STROBE,
        HS_FWD_HOLD,
        HS_REV_WAIT,
        HS_REV_ACK
    } hs_state_e;

    localparam int MODE_W = 3;

    function automatic logic mode_is_sw(input logic [MODE_W-1:0] m);
        return m[2:1] == 2'b00;
    endfunction

    function automatic logic mode_is_hw(input logic [MODE_W-1:0] m);
        return m[2:1] == 2'b01;
    endfunction

endpackage

// File: rtl/ecp_mode_reg.sv
module ecp_mode_reg
    import ecp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wmode,
    input  logic              wdir,
    input  logic              wstrobe,
    input  logic              wautofd,
    output logic [MODE_W-1:0] mode_q,
    output logic              dir_q,
    output logic              strobe_q,
    output logic              autofd_q,
    output logic              pend_q,
    output logic              leave_req
);

    logic [MODE_W-1:0] tgt_q;
    logic              accept;
    logic              fwd_leave;

    // A change is legal from a software mode, or when it goes to a software mode
    assign accept    = we && !pend_q && (mode_is_sw(mode_q) || mode_is_sw(wmode));
    assign leave_req = accept && mode_is_hw(mode_q);
    assign fwd_leave = leave_req && !dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            tgt_q    <= '0;
            dir_q    <= 1'b0;
            strobe_q <= 1'b0;
            autofd_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (pend_q) begin
            mode_q <= tgt_q;
            pend_q <= 1'b0;
        end else if (we) begin
            strobe_q <= wstrobe;
            autofd_q <= wautofd;
            if (mode_q == 3'b001) dir_q <= wdir;
            if (accept) begin
                if (fwd_leave) begin
                    pend_q <= 1'b1;
                    tgt_q  <= wmode;
                end else begin
                    mode_q <= wmode;
                end
            end
        end
    end

endmodule

// File: rtl/ecp_hs_engine.sv
module ecp_hs_engine
    import ecp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dir,
    input  logic              addr_avail,
    input  logic [DATA_W-1:0] addr_byte,
    input  logic              data_avail,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              rev_full,
    input  logic              busy,
    input  logic              nack,
    input  logic [DATA_W-1:0] bus_in,
    output logic              addr_pop,
    output logic              data_pop,
    output logic              rev_push,
    output logic [DATA_W-1:0] byte_q,
    output logic              eng_nstrobe,
    output logic              eng_nautofd,
    output logic              idle
);

    hs_state_e state, nxt;
    logic      is_addr_q;
    logic      rev_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!run) begin
            nxt = HS_IDLE;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (dir)                           nxt = HS_REV_WAIT;
                    else if (addr_avail || data_avail) nxt = HS_FWD_STROBE;
                end
                HS_FWD_STROBE: if (busy)              nxt = HS_FWD_HOLD;
                HS_FWD_HOLD:   if (!busy)             nxt = HS_IDLE;
                HS_REV_WAIT:   if (!nack && !rev_full) nxt = HS_REV_ACK;
                HS_REV_ACK:    if (nack)              nxt = HS_REV_WAIT;
                default:                              nxt = HS_IDLE;
            endcase
        end
    end

    always_comb begin
        addr_pop    = run && (state == HS_IDLE) && !dir && addr_avail;
        data_pop    = run && (state == HS_IDLE) && !dir && !addr_avail && data_avail;
        rev_take    = run && (state == HS_REV_WAIT) && !nack && !rev_full;
        rev_push    = run && (state == HS_REV_ACK) && nack;
        eng_nstrobe = (state != HS_FWD_STROBE);
        unique case (state)
            HS_FWD_STROBE, HS_FWD_HOLD: eng_nautofd = !is_addr_q;
            HS_REV_ACK:                 eng_nautofd = 1'b0;
            default:                    eng_nautofd = 1'b1;
        endcase
        idle = (state == HS_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q    <= '0;
            is_addr_q <= 1'b0;
        end else if (addr_pop) begin
            byte_q    <= addr_byte;
            is_addr_q <= 1'b1;
        end else if (data_pop) begin
            byte_q    <= data_byte;
            is_addr_q <= 1'b0;
        end else if (rev_take) begin
            byte_q    <= bus_in;
        end
    end

endmodule

// File: rtl/ecp_mode_ctrl.sv
module ecp_mode_ctrl
    import ecp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_mode,
    input  logic              reg_dir,
    input  logic              reg_strobe,
    input  logic              reg_autofd,
    output logic [2:0]        mode_o,
    output logic              dir_o,
    input  logic              afifo_avail,
    input  logic [DATA_W-1:0] afifo_byte,
    output logic              afifo_pop,
    input  logic              dfifo_avail,
    input  logic [DATA_W-1:0] dfifo_byte,
    output logic              dfifo_pop,
    input  logic              rfifo_full,
    output logic              rfifo_push,
    output logic [DATA_W-1:0] rfifo_byte,
    output logic              xfer_idle_o,
    output logic              fwd_drained_o,
    output logic              pp_nstrobe_o,
    output logic              pp_nautofd_o,
    input  logic              pp_busy_i,
    input  logic              pp_nack_i,
    output logic [DATA_W-1:0] pp_data_o,
    input  logic [DATA_W-1:0] pp_data_i,
    output logic              pp_data_oe
);

    logic              sw_strobe, sw_autofd;
    logic              pend_w, leave_w, hw_run;
    logic              eng_nstrobe, eng_nautofd, eng_idle;
    logic [DATA_W-1:0] byte_w;
    logic              nstrobe_q, nautofd_q;

    ecp_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .wmode     (reg_mode),
        .wdir      (reg_dir),
        .wstrobe   (reg_strobe),
        .wautofd   (reg_autofd),
        .mode_q    (mode_o),
        .dir_q     (dir_o),
        .strobe_q  (sw_strobe),
        .autofd_q  (sw_autofd),
        .pend_q    (pend_w),
        .leave_req (leave_w)
    );

    assign hw_run = mode_is_hw(mode_o) && !pend_w && !leave_w;

    ecp_hs_engine #(.DATA_W(DATA_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (hw_run),
        .dir         (dir_o),
        .addr_avail  (afifo_avail),
        .addr_byte   (afifo_byte),
        .data_avail  (dfifo_avail),
        .data_byte   (dfifo_byte),
        .rev_full    (rfifo_full),
        .busy        (pp_busy_i),
        .nack        (pp_nack_i),
        .bus_in      (pp_data_i),
        .addr_pop    (afifo_pop),
        .data_pop    (dfifo_pop),
        .rev_push    (rfifo_push),
        .byte_q      (byte_w),
        .eng_nstrobe (eng_nstrobe),
        .eng_nautofd (eng_nautofd),
        .idle        (eng_idle)
    );

    // Registered pins: the only path to the port, so mode switches cannot glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nstrobe_q <= 1'b1;
            nautofd_q <= 1'b1;
        end else if (leave_w || pend_w) begin
            nstrobe_q <= 1'b1;
            nautofd_q <= 1'b1;
        end else if (mode_is_hw(mode_o)) begin
            nstrobe_q <= eng_nstrobe;
            nautofd_q <= eng_nautofd;
        end else begin
            nstrobe_q <= !sw_strobe;
            nautofd_q <= !sw_autofd;
        end
    end

    assign pp_nstrobe_o  = nstrobe_q;
    assign pp_nautofd_o  = nautofd_q;
    assign pp_data_o     = byte_w;
    assign pp_data_oe    = !dir_o;
    assign rfifo_byte    = byte_w;
    assign xfer_idle_o   = eng_idle;
    assign fwd_drained_o = eng_idle && !afifo_avail && !dfifo_avail;

endmodule

// File: rtl/ecp_mode_ctrl_chk.sv
module ecp_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_mode,
    input logic [2:0] mode_o,
    input logic       dir_o,
    input logic       pend,
    input logic       leave,
    input logic       afifo_pop,
    input logic       dfifo_pop,
    input logic       rfifo_push,
    input logic       pp_nack_i,
    input logic       pp_nstrobe_o,
    input logic       pp_nautofd_o
);

    a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !pend && mode_o[2:1] != 2'b00 && reg_mode[2:1] != 2'b00) |=> $stable(mode_o));

    a_r4_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'b001) |=> $stable(dir_o));

    a_r5_pop_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
        (afifo_pop || dfifo_pop) |-> (!dir_o && mode_o[2:1] == 2'b01 && !pend));

    a_r5_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({afifo_pop, dfifo_pop}));

    a_r6_leave_release: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (pp_nstrobe_o && pp_nautofd_o));

    a_r7_no_strobe_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[2:1] == 2'b01 && dir_o && $past(mode_o[2:1] == 2'b01)) |-> pp_nstrobe_o);

    a_r8_push_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rfifo_push |-> $past(!pp_nack_i));

endmodule

bind ecp_mode_ctrl ecp_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_mode     (reg_mode),
    .mode_o       (mode_o),
    .dir_o        (dir_o),
    .pend         (pend_w),
    .leave        (leave_w),
    .afifo_pop    (afifo_pop),
    .dfifo_pop    (dfifo_pop),
    .rfifo_push   (rfifo_push),
    .pp_nack_i    (pp_nack_i),
    .pp_nstrobe_o (pp_nstrobe_o),
    .pp_nautofd_o (pp_nautofd_o)
);

// File: tb/sim_ecp_mode_ctrl.sv
module sim_ecp_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_mode = '0;
    logic       reg_dir = 1'b0, reg_strobe = 1'b0, reg_autofd = 1'b0;
    logic [2:0] mode_o;
    logic       dir_o;
    logic       afifo_avail = 1'b0, dfifo_avail = 1'b0, rfifo_full = 1'b0;
    logic [7:0] afifo_byte = '0, dfifo_byte = '0, pp_data_i = '0;
    logic       afifo_pop, dfifo_pop, rfifo_push;
    logic [7:0] rfifo_byte, pp_data_o;
    logic       xfer_idle_o, fwd_drained_o;
    logic       pp_nstrobe_o, pp_nautofd_o, pp_data_oe;
    logic       pp_busy_i = 1'b0, pp_nack_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ecp_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_mode(reg_mode),
        .reg_dir(reg_dir), .reg_strobe(reg_strobe), .reg_autofd(reg_autofd),
        .mode_o(mode_o), .dir_o(dir_o),
        .afifo_avail(afifo_avail), .afifo_byte(afifo_byte), .afifo_pop(afifo_pop),
        .dfifo_avail(dfifo_avail), .dfifo_byte(dfifo_byte), .dfifo_pop(dfifo_pop),
        .rfifo_full(rfifo_full), .rfifo_push(rfifo_push), .rfifo_byte(rfifo_byte),
        .xfer_idle_o(xfer_idle_o), .fwd_drained_o(fwd_drained_o),
        .pp_nstrobe_o(pp_nstrobe_o), .pp_nautofd_o(pp_nautofd_o),
        .pp_busy_i(pp_busy_i), .pp_nack_i(pp_nack_i),
        .pp_data_o(pp_data_o), .pp_data_i(pp_data_i), .pp_data_oe(pp_data_oe)
    );

    // {start mode, written mode, expected mode}
    localparam logic [8:0] VEC [8] = '{
        {3'b000, 3'b011, 3'b011},
        {3'b001, 3'b101, 3'b101},
        {3'b011, 3'b101, 3'b011},
        {3'b010, 3'b001, 3'b001},
        {3'b101, 3'b110, 3'b101},
        {3'b110, 3'b000, 3'b000},
        {3'b111, 3'b001, 3'b001},
        {3'b100, 3'b010, 3'b100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] m, input logic d, input logic s, input logic a);
        reg_mode = m; reg_dir = d; reg_strobe = s; reg_autofd = a; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 mode", mode_o, 3'b000);
        chk("R1 dir", dir_o, 0);
        chk("R1 pins", {pp_nstrobe_o, pp_nautofd_o}, 2'b11);
        chk("R1 oe", pp_data_oe, 1);
        chk("R1 idle", xfer_idle_o, 1);

        // R3 transition table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][8:6], 1'b0, 1'b0, 1'b0);
            step(1);
            wr(VEC[i][5:3], 1'b0, 1'b0, 1'b0);
            step(2);
            chk($sformatf("R3 vector %0d", i), mode_o, VEC[i][2:0]);
            wr(3'b000, 1'b0, 1'b0, 1'b0);
            step(2);
        end

        // R2 software pins
        wr(3'b000, 1'b0, 1'b1, 1'b0);
        step(1);
        chk("R2 strobe bit", {pp_nstrobe_o, pp_nautofd_o}, 2'b01);
        wr(3'b001, 1'b0, 1'b0, 1'b1);
        step(1);
        chk("R2 autofd bit", {pp_nstrobe_o, pp_nautofd_o}, 2'b10);
        wr(3'b000, 1'b0, 1'b0, 1'b0);
        step(1);

        // R4 direction lock
        wr(3'b000, 1'b1, 1'b0, 0);
        chk("R4 dir in 000", dir_o, 0);
        wr(3'b001, 1'b1, 1'b0, 0);
        chk("R4 dir on entry", dir_o, 0);
        wr(3'b001, 1'b1, 1'b0, 0);
        chk("R4 dir in 001", dir_o, 1);
        chk("R4 oe off", pp_data_oe, 0);
        wr(3'b011, 1'b1, 1'b0, 0);
        wr(3'b011, 1'b0, 1'b0, 0);
        chk("R4 dir in 011", dir_o, 1);
        step(2);

        // R7 / R8 reverse handshake
        pp_data_i = 8'h5A; pp_nack_i = 1'b0;
        step(2);
        chk("R7 ack low", pp_nautofd_o, 0);
        chk("R7 no strobe", pp_nstrobe_o, 1);
        pp_nack_i = 1'b1;
        #1;
        chk("R8 push", rfifo_push, 1);
        chk("R8 byte", rfifo_byte, 8'h5A);
        step(2);
        chk("R8 ack released", pp_nautofd_o, 1);

        rfifo_full = 1'b1; pp_data_i = 8'h11; pp_nack_i = 1'b0;
        step(3);
        chk("R7 full blocks", pp_nautofd_o, 1);
        rfifo_full = 1'b0;
        step(2);
        chk("R7 after full", pp_nautofd_o, 0);

        // R9 reverse abort mid-transfer
        wr(3'b001, 1'b1, 1'b0, 1'b0);
        chk("R9 mode at once", mode_o, 3'b001);
        chk("R9 nautofd high", pp_nautofd_o, 1);
        pp_nack_i = 1'b1;
        #1;
        chk("R9 no push", rfifo_push, 0);
        step(1);
        chk("R9 still high", pp_nautofd_o, 1);

        // R5 forward handshake
        wr(3'b001, 1'b0, 1'b0, 1'b0);
        chk("R4 oe on", pp_data_oe, 1);
        afifo_byte = 8'h3C; afifo_avail = 1'b1;
        dfifo_byte = 8'hA5; dfifo_avail = 1'b1;
        wr(3'b011, 1'b0, 1'b0, 1'b0);
        chk("R5 address first", {afifo_pop, dfifo_pop}, 2'b10);
        step(1);
        afifo_avail = 1'b0;
        chk("R5 addr on bus", pp_data_o, 8'h3C);
        chk("R10 busy engine", xfer_idle_o, 0);
        step(1);
        chk("R5 addr strobe", {pp_nstrobe_o, pp_nautofd_o}, 2'b00);
        pp_busy_i = 1'b1;
        step(2);
        chk("R5 strobe released", pp_nstrobe_o, 1);
        pp_busy_i = 1'b0;
        step(1);
        chk("R5 data pop", {afifo_pop, dfifo_pop}, 2'b01);
        step(1);
        dfifo_avail = 1'b0;
        chk("R5 data on bus", pp_data_o, 8'hA5);
        step(1);
        chk("R5 data strobe", {pp_nstrobe_o, pp_nautofd_o}, 2'b01);

        // R6 forward abort before Busy
        wr(3'b001, 1'b0, 1'b0, 1'b0);
        chk("R6 lines released", {pp_nstrobe_o, pp_nautofd_o}, 2'b11);
        chk("R6 mode held", mode_o, 3'b011);
        wr(3'b000, 1'b0, 1'b1, 1'b1);
        chk("R6 mode applied", mode_o, 3'b001);
        step(1);
        chk("R6 write ignored", {pp_nstrobe_o, pp_nautofd_o}, 2'b11);

        // R10 drained flag
        chk("R10 drained", fwd_drained_o, 1);
        dfifo_avail = 1'b1;
        #1;
        chk("R10 not drained", fwd_drained_o, 0);
        chk("R10 idle", xfer_idle_o, 1);
        dfifo_avail = 1'b0;
        step(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule